// File: doc/BRIEF.md
# Counter Peripheral Host Register Interface

This block sits between an 8-bit host bus and the registers of a position or event counter. The host uses four strobes: an active-low enable, a select line that picks between data and control, an active-low read and an active-low write. From these the block recognises four kinds of cycle: data read, data write, status read and command write. A command write loads an internal byte pointer. Each data read or data write then reaches the register byte that the pointer names, and the pointer moves on by one. A multibyte register can therefore be streamed as consecutive bytes after a single command.

The register space has four parts. Two wide registers, preload and reference, are written by the host and driven out to the counter. One wide capture value arrives from the counter and can only be read. One mode byte is also written by the host. The host strobes are asynchronous to the system clock. They are synchronised, and a read or write takes effect when its strobe returns high. Read data is driven onto the bus as long as the read strobe is held low. A status read returns the counter's flag inputs, with the abnormal-input flag in the top bit.

Top module: `cnt_host_regs`

## Requirements
- R1: While `ce_n` is high, `d_oe` stays 0, and read or write strobes change neither the host registers nor the pointer.
- R2: A data write (`ce_n`=0, `cd`=0, `wr_n` pulsed low while `rd_n` is high) stores `d_in` into the byte the pointer selects. The stored value appears on the third rising clock edge after `wr_n` rises.
- R3: During a data read (`ce_n`=0, `cd`=0, `rd_n`=0, `wr_n`=1), `d_oe` is 1 and `d_out` carries the byte the pointer selects.
- R4: During a status read (`ce_n`=0, `cd`=1, `rd_n`=0), `d_out` is `{abn_flag, flags[6:0]}`. Bit 7 is the abnormal-input flag.
- R5: A command write (`cd`=1) loads the pointer from command bits [3:0]. A field value of 10 to 15 loads 0, and bits [7:4] are ignored.
- R6: Each completed data read or data write advances the pointer by one.
- R7: The pointer wraps from byte 9 to byte 0.
- R8: Byte map, least significant byte first: 0–2 preload, 3–5 reference, 6–8 `latch_val`, 9 mode.
- R9: A data write to bytes 6–8 changes no register, but it still advances the pointer.
- R10: A status read leaves the pointer unchanged.
- R11: After reset, preload, reference, mode and the pointer are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Bus enable, active low |
| cd | input | 1 | 1 = status/command, 0 = data |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| d_in | input | 8 | Host write data |
| d_out | output | 8 | Host read data |
| d_oe | output | 1 | Read data drive enable |
| latch_val | input | 24 | Captured count from the counter |
| abn_flag | input | 1 | Abnormal-input flag |
| flags | input | 7 | Other status flags |
| preload | output | 24 | Preload register |
| reference | output | 24 | Reference register |
| mode | output | 8 | Mode register |

## Verification
The bench builds the block with its default parameters: an 8-bit bus and 24-bit registers. This gives three bytes per register and a 10-byte map addressed by a 4-bit pointer. With these values the bench can walk the whole map and cross the wrap from byte 9 to byte 0. The 4-bit command field can also carry the unused codes 10 to 15, so the out-of-range load is exercised. The write latency is measured edge by edge at the pins, using these widths.

// File: rtl/cnt_host_regs.sv
module cnt_host_regs #(
  parameter int DW    = 8,
  parameter int REG_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             cd,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [DW-1:0]    d_in,
  output logic [DW-1:0]    d_out,
  output logic             d_oe,
  input  logic [REG_W-1:0] latch_val,
  input  logic             abn_flag,
  input  logic [DW-2:0]    flags,
  output logic [REG_W-1:0] preload,
  output logic [REG_W-1:0] reference,
  output logic [DW-1:0]    mode
);
  localparam int NB  = REG_W / DW;
  localparam int TOT = 3 * NB + 1;
  localparam int PW  = $clog2(TOT);
  localparam logic [PW-1:0] LASTP = PW'(TOT - 1);

  logic [2:0] ce_q, cd_q, rd_q, wr_q;
  logic [DW-1:0] din_cap;
  logic [PW-1:0] ptr;
  logic [1:0] region;
  logic [PW-1:0] sub;
  logic [DW-1:0] rd_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ce_q <= '1; cd_q <= '0; rd_q <= '1; wr_q <= '1;
    end else begin
      ce_q <= {ce_q[1:0], ce_n};
      cd_q <= {cd_q[1:0], cd};
      rd_q <= {rd_q[1:0], rd_n};
      wr_q <= {wr_q[1:0], wr_n};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) din_cap <= '0;
    else if (!wr_q[0]) din_cap <= d_in;

  wire rd_ev   = rd_q[1] & ~rd_q[2] & ~ce_q[2] & wr_q[2];
  wire wr_ev   = wr_q[1] & ~wr_q[2] & ~ce_q[2] & rd_q[2];
  wire data_rd = rd_ev & ~cd_q[2];
  wire data_wr = wr_ev & ~cd_q[2];
  wire cmd_wr  = wr_ev &  cd_q[2];

  always_comb begin
    if (ptr < PW'(NB)) begin
      region = 2'd0; sub = ptr;
    end else if (ptr < PW'(2 * NB)) begin
      region = 2'd1; sub = ptr - PW'(NB);
    end else if (ptr < PW'(3 * NB)) begin
      region = 2'd2; sub = ptr - PW'(2 * NB);
    end else begin
      region = 2'd3; sub = '0;
    end
  end

  always_comb
    case (region)
      2'd0:    rd_byte = preload[int'(sub) * DW +: DW];
      2'd1:    rd_byte = reference[int'(sub) * DW +: DW];
      2'd2:    rd_byte = latch_val[int'(sub) * DW +: DW];
      default: rd_byte = mode;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      preload <= '0; reference <= '0; mode <= '0;
    end else if (data_wr) begin
      case (region)
        2'd0:    preload[int'(sub) * DW +: DW]   <= din_cap;
        2'd1:    reference[int'(sub) * DW +: DW] <= din_cap;
        2'd3:    mode <= din_cap;
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ptr <= '0;
    else if (cmd_wr) ptr <= (din_cap[PW-1:0] <= LASTP) ? din_cap[PW-1:0] : '0;
    else if (data_rd || data_wr) ptr <= (ptr == LASTP) ? '0 : ptr + 1'b1;

  assign d_oe  = ~ce_n & ~rd_n & wr_n;
  assign d_out = cd ? {abn_flag, flags} : rd_byte;

  assert_ce_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && $past(ce_n) && $past(ce_n, 2) && $past(ce_n, 3))
      |-> ($stable(preload) && $stable(reference) && $stable(mode) && $stable(ptr)));

  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_rd || data_wr) && !cmd_wr && ptr != LASTP) |=> ptr == $past(ptr) + 1'b1);

  assert_ptr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_rd || data_wr) && !cmd_wr && ptr == LASTP) |=> ptr == '0);

  assert_latch_ro_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && region == 2'd2)
      |=> ($stable(preload) && $stable(reference) && $stable(mode)));

  assert_status_keeps_ptr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && cd_q[2]) |=> $stable(ptr));

  assert_cmd_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> ptr <= LASTP);
endmodule

// File: tb/tb_cnt_host_regs.sv
module tb_cnt_host_regs;
  logic clk = 0, rst_n = 0;
  logic ce_n = 1, cd = 0, rd_n = 1, wr_n = 1;
  logic [7:0] d_in = 0, d_out;
  logic d_oe;
  logic [23:0] latch_val = 24'hC31E5A;
  logic abn_flag = 0;
  logic [6:0] flags = 7'h15;
  logic [23:0] preload, reference;
  logic [7:0] mode;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cnt_host_regs dut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic sel, input logic [7:0] v, input logic en_n = 0);
    @(negedge clk); ce_n = en_n; cd = sel; d_in = v;
    @(negedge clk); wr_n = 0;
    repeat (4) @(negedge clk); wr_n = 1;
    repeat (4) @(negedge clk); ce_n = 1;
  endtask

  task automatic bus_rd(input logic sel, output logic [7:0] v, output logic oe);
    @(negedge clk); ce_n = 0; cd = sel; rd_n = 0;
    repeat (3) @(negedge clk); v = d_out; oe = d_oe;
    rd_n = 1;
    repeat (4) @(negedge clk); ce_n = 1;
  endtask

  task automatic t_reset;
    check(preload == 0, "R11", preload, 0);
    check(reference == 0, "R11", reference, 0);
    check(mode == 0, "R11", mode, 0);
  endtask

  task automatic t_writes;
    bus_wr(1, 8'h00);
    bus_wr(0, 8'h11); bus_wr(0, 8'h22); bus_wr(0, 8'h33);
    check(preload == 24'h332211, "R2 R8 preload", preload, 24'h332211);
    bus_wr(0, 8'h44); bus_wr(0, 8'h55); bus_wr(0, 8'h66);
    check(reference == 24'h665544, "R6 R8 reference", reference, 24'h665544);
  endtask

  task automatic t_latency;
    bus_wr(1, 8'h09);
    @(negedge clk); ce_n = 0; cd = 0; d_in = 8'h9C;
    @(negedge clk); wr_n = 0;
    repeat (4) @(negedge clk); wr_n = 1;
    @(posedge clk); @(posedge clk); #1;
    check(mode == 8'h00, "R2 latency early", mode, 0);
    @(posedge clk); #1;
    check(mode == 8'h9C, "R2 latency edge3", mode, 8'h9C);
    repeat (3) @(negedge clk); ce_n = 1;
  endtask

  task automatic t_reads;
    logic [7:0] v; logic oe;
    logic [7:0] exp [10] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66,
                             8'h5A, 8'h1E, 8'hC3, 8'h9C};
    bus_wr(1, 8'h00);
    for (int i = 0; i < 10; i++) begin
      bus_rd(0, v, oe);
      check(oe === 1'b1, "R3 oe", oe, 1);
      check(v == exp[i], "R3 R6 R8 read", v, exp[i]);
    end
    bus_rd(0, v, oe);
    check(v == 8'h11, "R7 wrap", v, 8'h11);
  endtask

  task automatic t_status;
    logic [7:0] v; logic oe;
    bus_wr(1, 8'h03);
    bus_rd(1, v, oe);
    check(v == 8'h15, "R4 status", v, 8'h15);
    abn_flag = 1;
    bus_rd(1, v, oe);
    check(v == 8'h95, "R4 abnormal bit7", v, 8'h95);
    abn_flag = 0;
    bus_rd(0, v, oe);
    check(v == 8'h44, "R10 pointer kept", v, 8'h44);
  endtask

  task automatic t_cmd_range;
    logic [7:0] v; logic oe;
    bus_wr(1, 8'h7C);
    bus_rd(0, v, oe);
    check(v == 8'h11, "R5 out of range", v, 8'h11);
    bus_wr(1, 8'hF4);
    bus_rd(0, v, oe);
    check(v == 8'h55, "R5 upper bits ignored", v, 8'h55);
  endtask

  task automatic t_latch_ro;
    logic [7:0] v; logic oe;
    bus_wr(1, 8'h06);
    bus_wr(0, 8'hFF); bus_wr(0, 8'hFF); bus_wr(0, 8'hFF);
    check(preload == 24'h332211, "R9 preload", preload, 24'h332211);
    check(reference == 24'h665544, "R9 reference", reference, 24'h665544);
    check(mode == 8'h9C, "R9 mode", mode, 8'h9C);
    bus_rd(0, v, oe);
    check(v == 8'h9C, "R9 pointer advanced", v, 8'h9C);
  endtask

  task automatic t_ce;
    logic [7:0] v; logic oe;
    bus_wr(1, 8'h01);
    @(negedge clk); ce_n = 1; cd = 0; rd_n = 0;
    repeat (2) @(negedge clk);
    check(d_oe == 0, "R1 bus released", d_oe, 0);
    rd_n = 1;
    repeat (4) @(negedge clk);
    bus_wr(0, 8'hAA, 1'b1);
    bus_wr(1, 8'h05, 1'b1);
    check(preload == 24'h332211, "R1 no write", preload, 24'h332211);
    bus_rd(0, v, oe);
    check(v == 8'h22, "R1 pointer kept", v, 8'h22);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_writes;
    t_latency;
    t_reads;
    t_status;
    t_cmd_range;
    t_latch_ro;
    t_ce;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule